// File: doc/BRIEF.md
# Four-Function Arithmetic-Logic Unit with Condition Flags

This block is a purely combinational arithmetic-logic unit for a small processor datapath. Two operand words and a two-bit function code go in. One result word and three condition flags come out: signed overflow, zero and sign. No clock is involved, so the outputs settle a short propagation delay after any input changes.

Addition and subtraction use a single shared adder. For subtraction the adder is fed the bitwise inverse of the second operand and a carry-in of one. The bitwise AND and XOR paths run alongside the adder, and a final multiplexer picks the result. The word width is a parameter with a default of 32. A second parameter chooses how the adder is built: either as a behavioural sum or as an explicit bit-by-bit ripple chain. The two forms give the same values.

Top module: `alu_core`

## Requirements
- R1: Function code 2'b00 drives the result to x_i + y_i, modulo 2^WIDTH.
- R2: Function code 2'b01 drives the result to x_i - y_i, modulo 2^WIDTH.
- R3: Function code 2'b10 drives the result to the bitwise AND of x_i and y_i.
- R4: Function code 2'b11 drives the result to the bitwise XOR of x_i and y_i.
- R5: zf_o is 1 exactly when every bit of the result is 0, for all four functions.
- R6: sf_o equals the most significant bit of the result, for all four functions.
- R7: For addition, of_o is 1 exactly when x_i and y_i have the same sign bit and the result's sign bit differs from it.
- R8: For subtraction, of_o is 1 exactly when x_i and y_i differ in sign bit and the result's sign bit differs from that of x_i.
- R9: For the AND and XOR functions, of_o is 0 whatever the operands are.
- R10: All outputs follow input changes without any clock edge.
- R11: WIDTH sets the operand and result width, and the behaviour above holds at a width of 8 as well as at the default of 32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_i | input | WIDTH | First operand |
| y_i | input | WIDTH | Second operand |
| func_i | input | 2 | Function code: 00 add, 01 subtract, 10 AND, 11 XOR |
| res_o | output | WIDTH | Result word |
| of_o | output | 1 | Signed overflow flag |
| zf_o | output | 1 | Zero flag |
| sf_o | output | 1 | Sign flag |

## Verification
The operand patterns are chosen so that each flag rule can be told apart from the others. Additions and subtractions at the signed limits show whether overflow follows the operand and result signs rather than the unsigned carry out of the top bit. For example, all-ones plus one wraps to zero with no overflow, while the most negative value plus itself wraps to zero with overflow. Equal operands under subtraction and XOR set the zero flag, and a logic operation whose result looks like an overflowing sum confirms that the overflow flag is held low. Random operands under every function are compared with an arithmetic model, and a narrow 8-bit instance shows that the width parameter is respected.

// File: rtl/alu_pkg.sv
package alu_pkg;
   typedef enum logic [1:0] {
      FN_ADD = 2'b00,
      FN_SUB = 2'b01,
      FN_AND = 2'b10,
      FN_XOR = 2'b11
   } alu_fn_e;

   localparam int ADDER_BEHAVIOURAL = 0;
   localparam int ADDER_RIPPLE      = 1;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
   parameter int WIDTH = 32,
   parameter int STYLE = 0
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             sub_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             c_msb_o,
   output logic             c_out_o
);
   localparam int LOW = WIDTH - 1;

   logic [WIDTH-1:0] b_eff;
   assign b_eff = sub_i ? ~b_i : b_i;

   generate
      if (STYLE == alu_pkg::ADDER_RIPPLE) begin : g_ripple
         logic [WIDTH:0] cy;
         assign cy[0] = sub_i;
         for (genvar k = 0; k < WIDTH; k++) begin : g_bit
            assign sum_o[k]  = a_i[k] ^ b_eff[k] ^ cy[k];
            assign cy[k+1]   = (a_i[k] & b_eff[k]) | (cy[k] & (a_i[k] ^ b_eff[k]));
         end
         assign c_msb_o = cy[WIDTH-1];
         assign c_out_o = cy[WIDTH];
      end else begin : g_behav
         logic [LOW:0] low_sum;
         logic [1:0]   top_sum;
         assign low_sum = {1'b0, a_i[LOW-1:0]} + {1'b0, b_eff[LOW-1:0]} + {{LOW{1'b0}}, sub_i};
         assign top_sum = {1'b0, a_i[WIDTH-1]} + {1'b0, b_eff[WIDTH-1]} + {1'b0, low_sum[LOW]};
         assign sum_o   = {top_sum[0], low_sum[LOW-1:0]};
         assign c_msb_o = low_sum[LOW];
         assign c_out_o = top_sum[1];
      end
   endgenerate

   always_comb begin
      // R2
      if (sub_i && (a_i == b_i)) begin
         sub_self_zero_chk: assert (sum_o == '0)
            else $error("subtracting an operand from itself is not zero");
      end
   end
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             xor_i,
   output logic [WIDTH-1:0] out_o
);
   logic [WIDTH-1:0] and_w;
   logic [WIDTH-1:0] xor_w;

   assign and_w = a_i & b_i;
   assign xor_w = a_i ^ b_i;
   assign out_o = xor_i ? xor_w : and_w;

   always_comb begin
      // R4
      if (xor_i) begin
         xor_undo_chk: assert ((out_o ^ b_i) == a_i)
            else $error("xor output does not recover the first operand");
      end
   end
endmodule

// File: rtl/alu_flags.sv
module alu_flags #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] res_i,
   input  logic             xs_i,
   input  logic             ys_i,
   input  alu_pkg::alu_fn_e fn_i,
   output logic             of_o,
   output logic             zf_o,
   output logic             sf_o
);
   import alu_pkg::*;

   logic rs;
   assign rs   = res_i[WIDTH-1];
   assign zf_o = ~|res_i;
   assign sf_o = rs;

   always_comb begin
      unique case (fn_i)
         FN_ADD:  of_o = (xs_i == ys_i) && (rs != xs_i);
         FN_SUB:  of_o = (xs_i != ys_i) && (rs != xs_i);
         default: of_o = 1'b0;
      endcase
   end

   always_comb begin
      // R5
      zero_not_negative_chk: assert (!(zf_o && sf_o))
         else $error("zero and sign flags both set");
   end
endmodule

// File: rtl/alu_core.sv
module alu_core #(
   parameter int WIDTH = 32,
   parameter int ADDER_STYLE = alu_pkg::ADDER_BEHAVIOURAL
) (
   input  logic [WIDTH-1:0] x_i,
   input  logic [WIDTH-1:0] y_i,
   input  logic [1:0]       func_i,
   output logic [WIDTH-1:0] res_o,
   output logic             of_o,
   output logic             zf_o,
   output logic             sf_o
);
   import alu_pkg::*;

   localparam int MSB = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("alu_core: WIDTH must be at least 2");
      end
      if ((ADDER_STYLE != ADDER_BEHAVIOURAL) && (ADDER_STYLE != ADDER_RIPPLE)) begin : g_bad_style
         $error("alu_core: unknown ADDER_STYLE");
      end
   endgenerate

   alu_fn_e          fn;
   logic [WIDTH-1:0] arith_w;
   logic [WIDTH-1:0] logic_w;
   logic             c_msb;
   logic             c_out;

   assign fn = alu_fn_e'(func_i);

   alu_addsub #(.WIDTH(WIDTH), .STYLE(ADDER_STYLE)) u_addsub (
      .a_i     (x_i),
      .b_i     (y_i),
      .sub_i   (fn == FN_SUB),
      .sum_o   (arith_w),
      .c_msb_o (c_msb),
      .c_out_o (c_out)
   );

   alu_logic #(.WIDTH(WIDTH)) u_logic (
      .a_i   (x_i),
      .b_i   (y_i),
      .xor_i (fn == FN_XOR),
      .out_o (logic_w)
   );

   assign res_o = func_i[1] ? logic_w : arith_w;

   alu_flags #(.WIDTH(WIDTH)) u_flags (
      .res_i (res_o),
      .xs_i  (x_i[MSB]),
      .ys_i  (y_i[MSB]),
      .fn_i  (fn),
      .of_o  (of_o),
      .zf_o  (zf_o),
      .sf_o  (sf_o)
   );

   always_comb begin
      // R7 R8
      if (!func_i[1]) begin
         carry_overflow_chk: assert (of_o == (c_out ^ c_msb))
            else $error("sign-based overflow disagrees with the carry chain");
      end
      // R9
      if (func_i[1]) begin
         no_overflow_chk: assert (!of_o)
            else $error("overflow raised by a logic function");
      end
      // R3
      if (fn == FN_AND) begin
         and_subset_chk: assert ((res_o & ~x_i) == '0 && (res_o & ~y_i) == '0)
            else $error("and result has a bit absent from an operand");
      end
   end
endmodule

// File: tb/sim_alu_core.sv
module sim_alu_core;
   localparam int W = 32;
   localparam int NV = 13;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #5 clk = ~clk;

   logic [W-1:0] x, y, res;
   logic [1:0]   fn;
   logic         of, zf, sf;

   logic [7:0]   x8, y8, res8;
   logic [1:0]   fn8;
   logic         of8, zf8, sf8;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;

   alu_core #(.WIDTH(W)) u0 (
      .x_i(x), .y_i(y), .func_i(fn), .res_o(res), .of_o(of), .zf_o(zf), .sf_o(sf)
   );

   alu_core #(.WIDTH(8), .ADDER_STYLE(1)) u_narrow (
      .x_i(x8), .y_i(y8), .func_i(fn8), .res_o(res8), .of_o(of8), .zf_o(zf8), .sf_o(sf8)
   );

   // {fn, x, y, result, of, zf, sf}
   localparam logic [100:0] TBL [NV] = '{
      {2'd0, 32'h00000001, 32'h00000002, 32'h00000003, 3'b000},
      {2'd0, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 3'b101},
      {2'd0, 32'h80000000, 32'h80000000, 32'h00000000, 3'b110},
      {2'd0, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 3'b010},
      {2'd1, 32'h00000005, 32'h00000005, 32'h00000000, 3'b010},
      {2'd1, 32'h80000000, 32'h00000001, 32'h7FFFFFFF, 3'b100},
      {2'd1, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h80000000, 3'b101},
      {2'd1, 32'h00000000, 32'h00000001, 32'hFFFFFFFF, 3'b001},
      {2'd2, 32'hF0F0F0F0, 32'h0FF00FF0, 32'h00F000F0, 3'b000},
      {2'd2, 32'h80000000, 32'h80000001, 32'h80000000, 3'b001},
      {2'd3, 32'hAAAAAAAA, 32'hAAAAAAAA, 32'h00000000, 3'b010},
      {2'd3, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h80000000, 3'b001},
      {2'd1, 32'h80000000, 32'h80000000, 32'h00000000, 3'b010}
   };

   function automatic string rq(input logic [1:0] f);
      case (f)
         2'd0: return "R1/R7";
         2'd1: return "R2/R8";
         2'd2: return "R3/R9";
         default: return "R4/R9";
      endcase
   endfunction

   task automatic check(input string req, input logic [W-1:0] er,
                        input logic eo, input logic ez, input logic es);
      n_chk++;
      if (res !== er || of !== eo || zf !== ez || sf !== es) begin
         n_bad++;
         $display("FAIL %s fn=%0d x=%h y=%h: got res=%h of=%b zf=%b sf=%b, expected res=%h of=%b zf=%b sf=%b",
                  req, fn, x, y, res, of, zf, sf, er, eo, ez, es);
      end
   endtask

   task automatic model_check(input string req);
      logic [W-1:0] r;
      logic o;
      case (fn)
         2'd0: begin r = x + y; o = (x[W-1] == y[W-1]) && (r[W-1] != x[W-1]); end
         2'd1: begin r = x - y; o = (x[W-1] != y[W-1]) && (r[W-1] != x[W-1]); end
         2'd2: begin r = x & y; o = 1'b0; end
         default: begin r = x ^ y; o = 1'b0; end
      endcase
      check(req, r, o, (r == '0), r[W-1]);
   endtask

   task automatic check8(input logic [1:0] f, input logic [7:0] a, input logic [7:0] b,
                         input logic [7:0] er, input logic eo, input logic ez, input logic es);
      fn8 = f; x8 = a; y8 = b;
      #1;
      n_chk++;
      if (res8 !== er || of8 !== eo || zf8 !== ez || sf8 !== es) begin
         n_bad++;
         $display("FAIL R11 fn=%0d x=%h y=%h: got res=%h of=%b zf=%b sf=%b, expected res=%h of=%b zf=%b sf=%b",
                  f, a, b, res8, of8, zf8, sf8, er, eo, ez, es);
      end
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 20000) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      x = '0; y = '0; fn = 2'd0;
      x8 = '0; y8 = '0; fn8 = 2'd0;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      @(negedge clk);
      // reset-time state: zero operands add to zero (R5, R6)
      check("R5/R6 idle", '0, 1'b0, 1'b1, 1'b0);

      for (int i = 0; i < NV; i++) begin
         @(posedge clk);
         fn = TBL[i][100:99]; x = TBL[i][98:67]; y = TBL[i][66:35];
         @(negedge clk);
         check(rq(fn), TBL[i][34:3], TBL[i][2], TBL[i][1], TBL[i][0]);
      end

      // R10: outputs change between edges with no clock involved
      @(negedge clk);
      fn = 2'd0; x = 32'h10; y = 32'h20;
      #1 check("R10 no-clock add", 32'h30, 1'b0, 1'b0, 1'b0);
      fn = 2'd1;
      #1 check("R10 no-clock sub", 32'hFFFFFFF0, 1'b0, 1'b0, 1'b1);
      fn = 2'd3; y = 32'h10;
      #1 check("R10 no-clock xor", 32'h0, 1'b0, 1'b1, 1'b0);

      // random operands, all functions (R1-R9 via model; R5 R6 flags)
      for (int i = 0; i < 400; i++) begin
         @(posedge clk);
         fn = 2'(i % 4);
         x = $urandom; y = $urandom;
         if (i % 16 == 5) y = x;
         if (i % 16 == 9) x = 32'h80000000;
         @(negedge clk);
         model_check({rq(fn), " R5 R6 random"});
      end

      // R11: 8-bit instance with the ripple adder
      @(negedge clk);
      check8(2'd0, 8'h7F, 8'h01, 8'h80, 1'b1, 1'b0, 1'b1);
      check8(2'd0, 8'hFF, 8'h01, 8'h00, 1'b0, 1'b1, 1'b0);
      check8(2'd1, 8'h80, 8'h01, 8'h7F, 1'b1, 1'b0, 1'b0);
      check8(2'd2, 8'hC3, 8'h5A, 8'h42, 1'b0, 1'b0, 1'b0);
      check8(2'd3, 8'h7F, 8'hFF, 8'h80, 1'b0, 1'b0, 1'b1);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule